// File: doc/BRIEF.md
# Protection-Aware Memory Checksum Unit

This unit produces a 16-bit checksum over a program memory image. It reads the image through a synchronous read port with one cycle of latency, issuing one read per clock. It also takes a configuration word and four identification words as inputs. A two-bit protection field in the configuration word sets how many low-address words are summed. The same field sets whether a value packed from the identification words is added.

A start pulse captures the configuration and ID inputs, so they need not be held afterwards. The unit then walks the chosen range from address zero upward. It holds the result on `sum_out` and marks completion with a one-cycle `done` pulse. A second start pulse that arrives during a run is dropped. The default geometry is a 2048-word memory.

Top module: `cks_unit`

## Requirements
- R1: All additions wrap modulo 2^16, and carries out of bit 15 are lost.
- R2: Every run adds the configuration word ANDed with 0x3FFF, so bits 15:14 never reach the result.
- R3: Configuration bits 7:6 = 2'b11 (unprotected) sum addresses 0 to 0x7FF, and no ID value is added.
- R4: Bits 7:6 = 2'b10 sum addresses 0 to 0x3FF and add the packed ID value.
- R5: Bits 7:6 = 2'b01 sum addresses 0 to 0x1FF and add the packed ID value.
- R6: Bits 7:6 = 2'b00 issue no memory reads, and the result is the masked configuration word plus the packed ID value.
- R7: The packed ID value is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, where id0 is `id_words[15:0]` and idK is `id_words[16K+15:16K]`. For example, IDs 0x12, 0x37, 0x04, 0x26 pack to 0x2746.
- R8: An image of all 0x3FFF words with configuration 0x3FFF yields 0x37FF.
- R9: A run issues exactly N reads, where N is the word count chosen in R3 to R6. The reads fall on consecutive cycles at addresses 0, 1, 2, and so on. `mem_rd` is high only while `busy` is high.
- R10: A `start` pulse while `busy` is high is ignored. The running result and its timing are unchanged.
- R11: After reset, `busy`, `done` and `sum_out` are 0. `done` is a one-cycle pulse seen N+2 clock edges after the accepting edge, counting that edge as the first. `busy` is low while `done` is high. `sum_out` changes only at the edge that raises `done`.
- R12: A `start` pulse in the same cycle as `done` is accepted, and a new run begins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; takes effect only when idle |
| cfg_word | input | 16 | Configuration word carrying the protection field |
| id_words | input | 64 | Four ID words, id0 in bits 15:0 |
| mem_rd | output | 1 | Read enable for the memory port |
| mem_addr | output | ADDR_W (11) | Read address |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| sum_out | output | 16 | Last completed checksum |

## Verification
Two events can fall in the same cycle. A new start can coincide with the completion pulse of the previous run. A stray start can also arrive while a walk is in progress. The bench provokes the first case by raising `start` in exactly the cycle where `done` is seen high, and the second by pulsing `start` with a different configuration mid-walk. The overlap at completion is judged by checking that the old result is shown with `done` and that the new run gives its own checksum with the full latency. The stray start is judged by checking that the first run's sum, read count and latency are unchanged.

// File: rtl/cks_pkg.sv
package cks_pkg;

    localparam int WORD_W   = 16;
    localparam int NIB_W    = 4;
    localparam int PROT_LSB = 6;
    localparam logic [WORD_W-1:0] CFG_KEEP = 16'h3FFF;

    typedef enum logic [1:0] {
        PROT_ALL  = 2'b00,
        PROT_3Q   = 2'b01,
        PROT_HALF = 2'b10,
        PROT_OFF  = 2'b11
    } prot_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_WALK  = 2'b01,
        ST_FLUSH = 2'b10
    } walk_st_e;

    typedef struct packed {
        prot_e prot;
        logic  use_id;
        logic  skip_mem;
        logic [1:0] shift;
    } plan_t;

    function automatic plan_t decode_prot(input logic [WORD_W-1:0] cfg);
        plan_t p;
        p.prot = prot_e'(cfg[PROT_LSB +: 2]);
        unique case (p.prot)
            PROT_OFF:  begin p.use_id = 1'b0; p.skip_mem = 1'b0; p.shift = 2'd0; end
            PROT_HALF: begin p.use_id = 1'b1; p.skip_mem = 1'b0; p.shift = 2'd1; end
            PROT_3Q:   begin p.use_id = 1'b1; p.skip_mem = 1'b0; p.shift = 2'd2; end
            default:   begin p.use_id = 1'b1; p.skip_mem = 1'b1; p.shift = 2'd0; end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cks_plan.sv
module cks_plan
    import cks_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int NUM_ID = 4
) (
    input  logic [WORD_W-1:0]        cfg_word,
    input  logic [NUM_ID*WORD_W-1:0] id_words,
    output logic                     skip_mem,
    output logic [ADDR_W-1:0]        last_addr,
    output logic [WORD_W-1:0]        seed
);
    localparam int PACK_W = NUM_ID * NIB_W;

    plan_t              plan;
    logic [PACK_W-1:0]  id_pack;
    logic [WORD_W-1:0]  id_term;
    logic               unused_upper_bits;

    assign plan = decode_prot(cfg_word);

    for (genvar g = 0; g < NUM_ID; g++) begin : g_nib
        assign id_pack[(NUM_ID-1-g)*NIB_W +: NIB_W] = id_words[g*WORD_W +: NIB_W];
    end

    assign id_term   = WORD_W'(id_pack);
    assign skip_mem  = plan.skip_mem;
    assign last_addr = {ADDR_W{1'b1}} >> plan.shift;
    assign seed      = (cfg_word & CFG_KEEP) + (plan.use_id ? id_term : '0);

    assign unused_upper_bits = ^{id_words, cfg_word};

endmodule

// File: rtl/cks_walker.sv
module cks_walker
    import cks_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              skip_mem,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              busy,
    output logic              fin,
    output logic              skip_held
);
    walk_st_e          state;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            last_q    <= '0;
            skip_held <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        addr_q    <= '0;
                        last_q    <= last_addr;
                        skip_held <= skip_mem;
                        state     <= skip_mem ? ST_FLUSH : ST_WALK;
                    end
                end
                ST_WALK: begin
                    if (addr_q == last_q) begin
                        state <= ST_FLUSH;
                    end else begin
                        addr_q <= addr_q + ADDR_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_rd   = (state == ST_WALK);
    assign mem_addr = addr_q;
    assign busy     = (state != ST_IDLE);
    assign fin      = (state == ST_FLUSH);

endmodule

// File: rtl/cks_accum.sv
module cks_accum
    import cks_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] seed,
    input  logic              rd_issued,
    input  logic [WORD_W-1:0] rd_data,
    input  logic              fin,
    output logic [WORD_W-1:0] sum_out,
    output logic              done
);
    logic              rd_vld;
    logic [WORD_W-1:0] acc;
    logic [WORD_W-1:0] acc_nxt;

    assign acc_nxt = rd_vld ? acc + rd_data : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_vld  <= 1'b0;
            acc     <= '0;
            sum_out <= '0;
            done    <= 1'b0;
        end else begin
            rd_vld <= rd_issued;
            done   <= fin;
            if (load) begin
                acc <= seed;
            end else begin
                acc <= acc_nxt;
            end
            if (fin) begin
                sum_out <= acc_nxt;
            end
        end
    end

endmodule

// File: rtl/cks_unit.sv
module cks_unit
    import cks_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int NUM_ID = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [15:0]               cfg_word,
    input  logic [NUM_ID*16-1:0]      id_words,
    output logic                      mem_rd,
    output logic [ADDR_W-1:0]         mem_addr,
    input  logic [15:0]               mem_rdata,
    output logic                      busy,
    output logic                      done,
    output logic [15:0]               sum_out
);
    logic              go;
    logic              skip_mem;
    logic              skip_held;
    logic              fin;
    logic [ADDR_W-1:0] last_addr;
    logic [WORD_W-1:0] seed;

    assign go = start && !busy;

    cks_plan #(.ADDR_W(ADDR_W), .NUM_ID(NUM_ID)) i_plan (
        .cfg_word  (cfg_word),
        .id_words  (id_words),
        .skip_mem  (skip_mem),
        .last_addr (last_addr),
        .seed      (seed)
    );

    cks_walker #(.ADDR_W(ADDR_W)) i_walker (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .skip_mem  (skip_mem),
        .last_addr (last_addr),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .busy      (busy),
        .fin       (fin),
        .skip_held (skip_held)
    );

    cks_accum i_accum (
        .clk       (clk),
        .rst       (rst),
        .load      (go),
        .seed      (seed),
        .rd_issued (mem_rd),
        .rd_data   (mem_rdata),
        .fin       (fin),
        .sum_out   (sum_out),
        .done      (done)
    );

endmodule

// File: rtl/cks_unit_chk.sv
module cks_unit_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [15:0]       sum_out,
    input logic              skip_held
);
    assert_rd_in_run_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> busy);

    assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd) && !$past(rst)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_first_addr_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy) && mem_rd && !$past(rst)) |-> (mem_addr == '0));

    assert_no_read_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && skip_held) |-> !mem_rd);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_sum_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(rst)) |-> $stable(sum_out));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(rst)) |-> $stable(skip_held));

endmodule

bind cks_unit cks_unit_chk #(.ADDR_W(ADDR_W)) i_cks_unit_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .sum_out   (sum_out),
    .skip_held (skip_held)
);

// File: tb/test_cks_unit.sv
`timescale 1ns/1ps
module test_cks_unit;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   cfg_word = '0;
    logic [63:0]   id_words = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata;
    logic          busy;
    logic          done;
    logic [15:0]   sum_out;

    logic [15:0] mem [0:DEPTH-1];

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    int exp_next = 0;
    int mon_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (!rst && start && !busy) begin
            rd_count = 0;
            exp_next = 0;
            mon_bad  = 0;
        end else if (!rst && mem_rd) begin
            if (int'(mem_addr) != exp_next) mon_bad = mon_bad + 1;
            exp_next = exp_next + 1;
            rd_count = rd_count + 1;
        end
    end

    cks_unit #(.ADDR_W(AW), .NUM_ID(4)) i_cks_unit (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_word  (cfg_word),
        .id_words  (id_words),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .sum_out   (sum_out)
    );

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int words_for(input logic [15:0] cfg);
        case (cfg[7:6])
            2'b11:   return DEPTH;
            2'b10:   return DEPTH / 2;
            2'b01:   return DEPTH / 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] expect_sum(input logic [15:0] cfg, input logic [63:0] ids);
        logic [15:0] s;
        s = cfg & 16'h3FFF;
        if (cfg[7:6] != 2'b11)
            s = s + {ids[3:0], ids[19:16], ids[35:32], ids[51:48]};
        for (int a = 0; a < words_for(cfg); a++) s = s + mem[a];
        return s;
    endfunction

    function automatic logic [63:0] pack_ids(input logic [15:0] i0, input logic [15:0] i1,
                                             input logic [15:0] i2, input logic [15:0] i3);
        return {i3, i2, i1, i0};
    endfunction

    task automatic fill_pattern(input int mode);
        for (int a = 0; a < DEPTH; a++) begin
            case (mode)
                0:       mem[a] = 16'h3FFF;
                1:       mem[a] = 16'hFFFF;
                default: mem[a] = 16'((a * 40503 + 4660) & 16'hFFFF);
            endcase
        end
    endtask

    // Drives start at the current negedge; returns at the negedge where done is seen.
    task automatic run_once(input logic [15:0] cfg, input logic [63:0] ids,
                            output int lat, output logic [15:0] res);
        cfg_word = cfg;
        id_words = ids;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_word = 16'hA5A5;
        id_words = '1;
        lat = 1;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat = lat + 1;
        end
        res = sum_out;
    endtask

    task automatic scenario(input string req, input logic [15:0] cfg, input logic [63:0] ids);
        int lat;
        logic [15:0] res;
        logic [15:0] exp;
        exp = expect_sum(cfg, ids);
        run_once(cfg, ids, lat, res);
        check(req, int'(res), int'(exp));
        check({req, " latency R11"}, lat, words_for(cfg) + 2);
        check({req, " reads R9"}, rd_count, words_for(cfg));
        check({req, " order R9"}, mon_bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 reset busy", int'(busy), 0);
        check("R11 reset done", int'(done), 0);
        check("R11 reset sum", int'(sum_out), 0);
    endtask

    task automatic t_blank();
        int lat;
        logic [15:0] res;
        fill_pattern(0);
        run_once(16'h3FFF, '0, lat, res);
        check("R8 blank checksum", int'(res), 16'h37FF);
    endtask

    task automatic t_id_example();
        int lat;
        logic [15:0] res;
        run_once(16'h0000, pack_ids(16'h12, 16'h37, 16'h04, 16'h26), lat, res);
        check("R7 id packing", int'(res), 16'h2746);
        check("R6 no reads", rd_count, 0);
    endtask

    task automatic t_start_while_busy();
        int lat;
        logic [15:0] exp;
        exp = expect_sum(16'h3FFF, '0);
        cfg_word = 16'h3FFF;
        id_words = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (20) begin @(negedge clk); lat = lat + 1; end
        cfg_word = 16'h0000;
        id_words = '1;
        start = 1'b1;
        @(negedge clk);
        lat = lat + 1;
        start = 1'b0;
        while (!done && lat < 3000) begin @(negedge clk); lat = lat + 1; end
        check("R10 stray start sum", int'(sum_out), int'(exp));
        check("R10 stray start latency", lat, DEPTH + 2);
        check("R10 stray start reads", rd_count, DEPTH);
    endtask

    task automatic t_back_to_back();
        int lat;
        logic [15:0] r1;
        logic [15:0] r2;
        logic [63:0] ids;
        ids = pack_ids(16'h5, 16'hA, 16'h3, 16'hC);
        run_once(16'h3F7F, ids, lat, r1);
        check("R12 first sum", int'(r1), int'(expect_sum(16'h3F7F, ids)));
        run_once(16'h3FBF, ids, lat, r2);
        check("R12 second sum", int'(r2), int'(expect_sum(16'h3FBF, ids)));
        check("R12 second latency", lat, DEPTH / 2 + 2);
    endtask

    task automatic t_done_pulse();
        @(negedge clk);
        check("R11 done one cycle", int'(done), 0);
        check("R11 sum held", int'(sum_out), int'(expect_sum(16'h3FBF, pack_ids(16'h5, 16'hA, 16'h3, 16'hC))));
    endtask

    initial begin
        fill_pattern(2);
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_blank();
        fill_pattern(2);
        scenario("R3 unprotected", 16'h3FFF, pack_ids(16'hF, 16'hF, 16'hF, 16'hF));
        scenario("R4 half", 16'h3FBF, pack_ids(16'h1, 16'h2, 16'h3, 16'h4));
        scenario("R5 three quarters", 16'h3F7F, pack_ids(16'hB, 16'h7, 16'h2, 16'h9));
        scenario("R6 all protected", 16'h2A3C, pack_ids(16'hFF3, 16'h0, 16'h8, 16'hE));
        scenario("R2 mask top bits", 16'hFFFF, '0);
        t_id_example();
        fill_pattern(1);
        scenario("R1 wrap", 16'h3FFF, '0);
        scenario("R1 wrap with ids", 16'hFFBF, pack_ids(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF));
        fill_pattern(2);
        t_start_while_busy();
        @(negedge clk);
        t_back_to_back();
        t_done_pulse();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule